// File: doc/BRIEF.md
# Bit Error Rate Receive Monitor

This block sits on the receive side of a link under test. It checks a serial bit stream against a 32-bit repetitive reference word that is regenerated locally. Each bit is qualified by a valid strobe. While the monitor is hunting, it shifts its reference phase until a long run of matching bits shows that it is aligned with the stream. It then holds lock until too many bits in one observation window are wrong.

While locked, the monitor counts received bits and bit errors in two saturating counters. Each counter has a sticky flag that shows it has saturated. A level change on the load input takes a snapshot of both counters into holding registers, restarts the live counters and clears the saturation flags. Two independent run detectors report a stream that is stuck at 0 or stuck at 1, whether or not the monitor is locked.

Top module: `bert_rx_monitor`

## Requirements
- R1: The sync output rises in the cycle that follows the 32nd consecutive valid bit that equals the expected reference bit. When the stream is aligned after reset, the first stream bit is compared with reference bit 0, and the sync output rises after exactly 32 bits.
- R2: While hunting, each mismatching bit moves the reference phase one extra position forward and restarts the match run. The monitor therefore locks onto a stream that starts at any rotation of the reference word.
- R3: Once locked, the monitor checks back-to-back 64-bit windows. The first window starts with the bit after lock. The 6th error inside one window drops sync in the cycle after that error. Five errors in a window keep lock, and errors from different windows are never added together.
- R4: Bits and errors are counted only when the sync output was already high as the bit arrived. The bit that completes lock is not counted. The bit that causes loss of lock is counted.
- R5: Any level change on the load input is registered twice on the clock. Two cycles later, the held counts show the live counts, and the live counters restart from zero.
- R6: The error counter (ERR_W bits, 24 by default) stops at its all-ones value. The error-overflow flag rises in the same cycle as the counter reaches that value and stays high until a load.
- R7: The bit counter (BIT_W bits, 32 by default) stops at its all-ones value. The bit-overflow flag rises in the same cycle as the counter reaches that value and stays high until a load.
- R8: The all-zeros flag rises after the 32nd consecutive valid 0 bit and falls after the first valid 1 bit.
- R9: The all-ones flag rises after the 32nd consecutive valid 1 bit and falls after the first valid 0 bit.
- R10: After synchronous reset, every flag and every held count is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Monitor clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial data bit |
| rx_valid | input | 1 | Qualifies rx_bit in this cycle |
| ref_word | input | 32 | Reference pattern, bit 0 first |
| load_lvl | input | 1 | Level input; any change requests a snapshot |
| sync_o | output | 1 | Pattern lock status |
| err_ovf_o | output | 1 | Error counter saturated |
| bit_ovf_o | output | 1 | Bit counter saturated |
| all_zero_o | output | 1 | Run of 32 zeros seen |
| all_one_o | output | 1 | Run of 32 ones seen |
| err_held_o | output | ERR_W | Snapshot of error count |
| bit_held_o | output | BIT_W | Snapshot of bit count |

## Verification
The hardest states to reach are the counter saturation points. With full widths, these states take millions of bits. The error counter also has to reach its limit without losing lock. The bench builds the monitor with narrow counters and places exactly five errors at the start of each 64-bit window. This walks the error count to its limit while lock holds, and the bit counter saturates a little later. Loss of lock is driven with errors split across a window boundary, so that a sixth error counts only inside one window.

// File: rtl/bert_pkg.sv
package bert_pkg;
  typedef enum logic {
    ST_HUNT   = 1'b0,
    ST_LOCKED = 1'b1
  } lock_state_e;
endpackage

// File: rtl/bert_sync_tracker.sv
module bert_sync_tracker
  import bert_pkg::*;
#(
  parameter int PAT_W    = 32,
  parameter int SYNC_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_ERR = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bit_in,
  input  logic             bit_vld,
  input  logic [PAT_W-1:0] pattern,
  output logic             locked_o,
  output logic             miss_o,
  output logic             count_en_o
);
  localparam int PH_W  = $clog2(PAT_W);
  localparam int RUN_W = $clog2(SYNC_RUN + 1);
  localparam int WIN_W = $clog2(WIN_LEN);
  localparam int WE_W  = $clog2(LOSS_ERR + 1);

  lock_state_e      state;
  logic [PH_W-1:0]  phase;
  logic [RUN_W-1:0] run;
  logic [WIN_W-1:0] wpos;
  logic [WE_W-1:0]  werr;

  function automatic logic [PH_W-1:0] step_phase(input logic [PH_W-1:0] p, input logic two);
    logic [PH_W:0] t;
    t = {1'b0, p} + (two ? (PH_W+1)'(2) : (PH_W+1)'(1));
    if (t >= (PH_W+1)'(PAT_W)) t = t - (PH_W+1)'(PAT_W);
    return t[PH_W-1:0];
  endfunction

  assign miss_o     = bit_vld && (bit_in != pattern[phase]);
  assign count_en_o = bit_vld && (state == ST_LOCKED);
  assign locked_o   = (state == ST_LOCKED);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_HUNT;
      phase <= '0;
      run   <= '0;
      wpos  <= '0;
      werr  <= '0;
    end else if (bit_vld) begin
      if (state == ST_HUNT) begin
        phase <= step_phase(phase, miss_o);
        if (miss_o) begin
          run <= '0;
        end else if (run == RUN_W'(SYNC_RUN - 1)) begin
          state <= ST_LOCKED;
          run   <= '0;
          wpos  <= '0;
          werr  <= '0;
        end else begin
          run <= run + 1'b1;
        end
      end else begin
        phase <= step_phase(phase, 1'b0);
        if (miss_o && werr == WE_W'(LOSS_ERR - 1)) begin
          state <= ST_HUNT;
          run   <= '0;
        end else if (wpos == WIN_W'(WIN_LEN - 1)) begin
          wpos <= '0;
          werr <= '0;
        end else begin
          wpos <= wpos + 1'b1;
          werr <= werr + WE_W'(miss_o);
        end
      end
    end
  end

  // R1: the match run never reaches its limit while hunting
  p_run_short_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT) |-> (run < RUN_W'(SYNC_RUN)));

  // R2: a mismatch while hunting never yields lock
  p_miss_stays_hunt_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_HUNT && miss_o) |=> (state == ST_HUNT));

  // R3: a locked window never holds the loss threshold
  p_window_limit_r3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOCKED) |-> (werr < WE_W'(LOSS_ERR)));
endmodule

// File: rtl/bert_counters.sv
module bert_counters #(
  parameter int ERR_W = 24,
  parameter int BIT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             count_en,
  input  logic             err_hit,
  input  logic             load_req,
  output logic [ERR_W-1:0] err_held_o,
  output logic [BIT_W-1:0] bit_held_o,
  output logic             err_ovf_o,
  output logic             bit_ovf_o
);
  localparam logic [ERR_W-1:0] ERR_MAX = '1;
  localparam logic [BIT_W-1:0] BIT_MAX = '1;

  logic [ERR_W-1:0] err_live;
  logic [BIT_W-1:0] bit_live;
  logic             err_inc;

  assign err_inc = count_en && err_hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      err_live   <= '0;
      bit_live   <= '0;
      err_held_o <= '0;
      bit_held_o <= '0;
      err_ovf_o  <= 1'b0;
      bit_ovf_o  <= 1'b0;
    end else if (load_req) begin
      err_held_o <= err_live;
      bit_held_o <= bit_live;
      err_live   <= ERR_W'(err_inc);
      bit_live   <= BIT_W'(count_en);
      err_ovf_o  <= 1'b0;
      bit_ovf_o  <= 1'b0;
    end else begin
      if (count_en && bit_live != BIT_MAX) begin
        bit_live <= bit_live + 1'b1;
        if (bit_live == BIT_MAX - 1'b1) bit_ovf_o <= 1'b1;
      end
      if (err_inc && err_live != ERR_MAX) begin
        err_live <= err_live + 1'b1;
        if (err_live == ERR_MAX - 1'b1) err_ovf_o <= 1'b1;
      end
    end
  end

  // R6: saturated error count does not wrap
  p_err_no_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (err_live == ERR_MAX && !load_req) |=> (err_live == ERR_MAX));

  // R6: overflow flag only while the counter sits at its limit
  p_err_flag_at_max_r6: assert property (@(posedge clk) disable iff (rst)
    err_ovf_o |-> (err_live == ERR_MAX));

  // R7: bit overflow flag is sticky until a load
  p_bit_ovf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (bit_ovf_o && !load_req) |=> bit_ovf_o);
endmodule

// File: rtl/bert_run_detect.sv
module bert_run_detect #(
  parameter int   RUN_LEN = 32,
  parameter logic MARK    = 1'b0
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  input  logic bit_vld,
  output logic flag_o
);
  localparam int CW = $clog2(RUN_LEN + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt    <= '0;
      flag_o <= 1'b0;
    end else if (bit_vld) begin
      if (bit_in == MARK) begin
        if (cnt != CW'(RUN_LEN)) cnt <= cnt + 1'b1;
        flag_o <= (cnt >= CW'(RUN_LEN - 1));
      end else begin
        cnt    <= '0;
        flag_o <= 1'b0;
      end
    end
  end

  // R8 (zeros instance) and R9 (ones instance): an opposite bit clears the flag
  p_run_break_r8: assert property (@(posedge clk) disable iff (rst)
    (bit_vld && bit_in != MARK) |=> !flag_o);
endmodule

// File: rtl/bert_rx_monitor.sv
module bert_rx_monitor #(
  parameter int PAT_W    = 32,
  parameter int SYNC_RUN = 32,
  parameter int WIN_LEN  = 64,
  parameter int LOSS_ERR = 6,
  parameter int RUN_LEN  = 32,
  parameter int ERR_W    = 24,
  parameter int BIT_W    = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rx_bit,
  input  logic             rx_valid,
  input  logic [PAT_W-1:0] ref_word,
  input  logic             load_lvl,
  output logic             sync_o,
  output logic             err_ovf_o,
  output logic             bit_ovf_o,
  output logic             all_zero_o,
  output logic             all_one_o,
  output logic [ERR_W-1:0] err_held_o,
  output logic [BIT_W-1:0] bit_held_o
);
  logic       load_s, load_q, load_req;
  logic       miss, count_en;
  logic [1:0] run_flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      load_s <= 1'b0;
      load_q <= 1'b0;
    end else begin
      load_s <= load_lvl;
      load_q <= load_s;
    end
  end
  assign load_req = load_s ^ load_q;

  bert_sync_tracker #(
    .PAT_W(PAT_W), .SYNC_RUN(SYNC_RUN), .WIN_LEN(WIN_LEN), .LOSS_ERR(LOSS_ERR)
  ) u_track (
    .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid), .pattern(ref_word),
    .locked_o(sync_o), .miss_o(miss), .count_en_o(count_en)
  );

  bert_counters #(.ERR_W(ERR_W), .BIT_W(BIT_W)) u_cnt (
    .clk(clk), .rst(rst), .count_en(count_en), .err_hit(miss), .load_req(load_req),
    .err_held_o(err_held_o), .bit_held_o(bit_held_o),
    .err_ovf_o(err_ovf_o), .bit_ovf_o(bit_ovf_o)
  );

  for (genvar g = 0; g < 2; g++) begin : g_run
    bert_run_detect #(.RUN_LEN(RUN_LEN), .MARK(g[0])) u_run (
      .clk(clk), .rst(rst), .bit_in(rx_bit), .bit_vld(rx_valid), .flag_o(run_flag[g])
    );
  end
  assign all_zero_o = run_flag[0];
  assign all_one_o  = run_flag[1];

  // R5: a recognised load clears both overflow flags on the next cycle
  p_load_clears_r5: assert property (@(posedge clk) disable iff (rst)
    load_req |=> (!err_ovf_o && !bit_ovf_o));

  // R8/R9: the two run flags are never high together
  p_runs_exclusive_r9: assert property (@(posedge clk) disable iff (rst)
    !(all_zero_o && all_one_o));
endmodule

// File: tb/test_bert_rx_monitor.sv
module test_bert_rx_monitor;
  localparam int EW = 4;
  localparam int BW = 8;
  localparam logic [31:0] PAT = 32'hB38F_0A6D;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          rx_bit = 1'b0;
  logic          rx_valid = 1'b0;
  logic          load_lvl = 1'b0;
  logic          sync_o, err_ovf_o, bit_ovf_o, all_zero_o, all_one_o;
  logic [EW-1:0] err_held_o;
  logic [BW-1:0] bit_held_o;

  int checks = 0;
  int fails  = 0;
  int tp     = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  bert_rx_monitor #(.ERR_W(EW), .BIT_W(BW)) i_bert_rx_monitor (
    .clk(clk), .rst(rst), .rx_bit(rx_bit), .rx_valid(rx_valid), .ref_word(PAT),
    .load_lvl(load_lvl), .sync_o(sync_o), .err_ovf_o(err_ovf_o), .bit_ovf_o(bit_ovf_o),
    .all_zero_o(all_zero_o), .all_one_o(all_one_o),
    .err_held_o(err_held_o), .bit_held_o(bit_held_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rx_valid = 1'b0;
    load_lvl = 1'b0;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    tp = 0;
  endtask

  task automatic send_bit(input logic b);
    rx_valid = 1'b1;
    rx_bit   = b;
    @(posedge clk);
    #2 rx_valid = 1'b0;
  endtask

  task automatic send_pat(input bit flip);
    send_bit(PAT[tp] ^ flip);
    tp = (tp + 1) % 32;
  endtask

  task automatic do_load();
    load_lvl = ~load_lvl;
    repeat (2) @(posedge clk);
    #2;
  endtask

  initial begin
    #(8 * 150000);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int n;
    // R10: reset state
    do_reset();
    check("R10 sync", sync_o, 0);
    check("R10 flags", {err_ovf_o, bit_ovf_o, all_zero_o, all_one_o}, 0);
    check("R10 held", {err_held_o, bit_held_o}, 0);

    // R1: aligned lock on the 32nd bit
    for (int i = 0; i < 31; i++) send_pat(1'b0);
    check("R1 before 32", sync_o, 0);
    send_pat(1'b0);
    check("R1 at 32", sync_o, 1);

    // R3: five errors per window hold lock, sixth in one window drops it
    for (int j = 0; j < 64; j++) send_pat(j inside {0, 1, 2, 61, 62});
    check("R3 five errors", sync_o, 1);
    for (int j = 0; j < 41; j++) begin
      send_pat(j inside {0, 1, 2, 20, 21, 40});
      if (j == 39) check("R3 across boundary", sync_o, 1);
    end
    check("R3 sixth error", sync_o, 0);
    do_load();
    check("R4 bits counted", bit_held_o, 105);
    check("R5 errors held", err_held_o, 11);

    // R6 / R7: saturation
    do_reset();
    for (int i = 0; i < 32; i++) send_pat(1'b0);
    for (int j = 0; j < 300; j++) begin
      send_pat(j < 256 && (j % 64) < 5);
      if (j == 131) check("R6 before max", err_ovf_o, 0);
      if (j == 132) check("R6 at max", err_ovf_o, 1);
      if (j == 253) check("R7 before max", bit_ovf_o, 0);
      if (j == 254) check("R7 at max", bit_ovf_o, 1);
    end
    check("R6 flag held", err_ovf_o, 1);
    check("R3 lock kept", sync_o, 1);
    do_load();
    check("R6 saturated count", err_held_o, 15);
    check("R7 saturated count", bit_held_o, 255);
    check("R6 flag cleared", err_ovf_o, 0);
    check("R7 flag cleared", bit_ovf_o, 0);
    do_load();
    check("R5 live cleared err", err_held_o, 0);
    check("R5 live cleared bits", bit_held_o, 0);

    // R8 / R9: run detectors
    do_reset();
    for (int i = 0; i < 31; i++) send_bit(1'b0);
    check("R8 31 zeros", all_zero_o, 0);
    send_bit(1'b0);
    check("R8 32 zeros", all_zero_o, 1);
    for (int i = 0; i < 8; i++) send_bit(1'b0);
    check("R8 long run", all_zero_o, 1);
    send_bit(1'b1);
    check("R8 broken", all_zero_o, 0);
    for (int i = 0; i < 30; i++) send_bit(1'b1);
    check("R9 31 ones", all_one_o, 0);
    send_bit(1'b1);
    check("R9 32 ones", all_one_o, 1);
    send_bit(1'b0);
    check("R9 broken", all_one_o, 0);

    // R2: lock from a rotated start
    do_reset();
    tp = 13;
    n = 0;
    while (!sync_o && n < 3000) begin
      send_pat(1'b0);
      n++;
    end
    check("R2 locked", sync_o, 1);
    check("R2 not early", int'(n >= 32), 1);
    for (int j = 0; j < 64; j++) send_pat(1'b0);
    check("R2 lock kept", sync_o, 1);
    do_load();
    check("R2 aligned no errors", err_held_o, 0);
    check("R4 hunt not counted", bit_held_o, 64);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule